// File: doc/BRIEF.md
# NOR Flash Command Array Model

This block is a synthesizable behavioural model of a small parallel NOR flash, meant to stand in for a real part in simulation and on FPGA prototypes. A host reaches it through a simple strobed register interface: an address, write data with a write strobe, and a read strobe that returns a registered word. A ready output goes low while an embedded operation runs.

Every cell powers up erased, at all ones. Stored data is changed only by specific multi-write command sequences. Programming can only clear bits, so the new content is the old word ANDed with the written word. Erase works on a whole sector and leaves every word of it at all ones. A sequence that breaks off part way is dropped. The model also provides a buffered program of up to 32 words, a device-information (query) read mode, an identification read mode, and a one-way lock. The upper half of the address space is a secure region, and once locked it refuses program and erase.

In this model the word address is 7 bits wide. Sectors are 16 words. Buffer pages are 32 words, aligned on 32-word boundaries. The secure region covers addresses 64 to 127. In the tables below, the word written in a command cycle is written "code@address", and only the low byte of the data is compared.

Top module: `nor_cmd_array`

## Requirements
- R1: After reset, every word reads 0xFFFF in array mode, ready is 1 and err is 0.
- R2: The word program sequence is AA@0x55, 55@0x2A, A0@0x55, then data@target. It stores the old word AND the data. The data cycle is pure data, so a low byte of F0 does not act as a reset command.
- R3: The erase sequence is AA@0x55, 55@0x2A, 80@0x55, AA@0x55, 55@0x2A, then 30@any address inside the sector. When it completes, all 16 words of that sector (address bits [6:4]) read 0xFFFF, and other sectors are unchanged.
- R4: Erase first preprograms the sector. After its first 16 busy cycles, and before it completes, every word of the sector reads 0x0000.
- R5: If any cycle of a command sequence has the wrong address or code, the sequencer returns to idle and no stored word changes.
- R6: After the last write of a program sequence (word or buffer), ready is low for exactly 8 cycles. After the last write of an erase sequence, it is low for 16 + 20 cycles. Writes that arrive while ready is low are ignored.
- R7: Writing 98@0x55 from array mode or identification mode enters query mode. In query mode, addresses 0x10, 0x11 and 0x12 read 0x0051, 0x0052 and 0x0059, address 0x13 reads the buffer size (32), and all other addresses read 0.
- R8: The sequence AA@0x55, 55@0x2A, 90@0x55 enters identification mode. In that mode address 0 reads 0x00A5, address 1 reads 0x5A3C, and address 3 reads 0x0080 when the secure region is locked and 0x0000 otherwise.
- R9: A write with low byte F0 to any address, outside a data cycle, returns the model to array mode, abandons any partial sequence and clears err.
- R10: The buffered program sequence is the unlock pair, then 25@page, then (count−1)@page, then count data writes inside the page, then 29@page. After the program busy time, each loaded word is ANDed into its location together with the others.
- R11: The buffered program is aborted, err is set to 1, and no word changes and ready stays high, in any of these cases: a count field above 31, any buffer-phase address outside the page, or a wrong confirm.
- R12: The sequence AA@0x55, 55@0x2A, 48@0x55 locks the secure region permanently. After that, program, erase and buffered program aimed at addresses 64–127 are dropped, with no busy time and no data change. The main array still accepts them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; returns the array to all ones |
| addr | input | 7 | Word address for reads and command writes |
| wdata | input | 16 | Write data or command code (low byte) |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; rdata updates at the same edge |
| rdata | output | 16 | Registered read word (array, identification or query data) |
| ready | output | 1 | 1 when idle, 0 while program or erase runs |
| err | output | 1 | Sticky buffered-program abort flag |

## Verification
The program path is tested in four ways: overlapping bit patterns written to one word, a word whose data byte is F0, a full 32-word page in which each word clears a different bit, and a short three-word buffer spread across a page. Together these show AND semantics as distinct from overwrite, and show that data cycles are kept apart from command decode. The sequences are also broken on purpose in several ways: a wrong address, a wrong code, writes issued while busy, an oversized count, an address outside the page, and writes aimed at the locked region. Each of these must leave the array untouched. Some must also set err, and others must not. A read taken in the middle of an erase separates the preprogram phase from the final erase. The ready line is compared against a behavioural model on every clock, which pins down the busy length of each operation.

// File: rtl/nor_pkg.sv
// Shared types and command codes for the NOR flash command array model.
// Assumes command codes are carried in the low byte of a write.
package nor_pkg;
    typedef enum logic [1:0] {MODE_ARRAY, MODE_IDENT, MODE_QUERY} rd_mode_t;

    typedef enum logic [3:0] {
        SEQ_IDLE, SEQ_UL1, SEQ_UL2, SEQ_PROG, SEQ_ER1, SEQ_ER2, SEQ_ER3,
        SEQ_BCNT, SEQ_BDATA, SEQ_BCONF
    } seq_t;

    typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_ERASE, OP_BUF} op_t;

    localparam logic [7:0] CMD_KEY1     = 8'hAA;
    localparam logic [7:0] CMD_KEY2     = 8'h55;
    localparam logic [7:0] CMD_PROG     = 8'hA0;
    localparam logic [7:0] CMD_ERSETUP  = 8'h80;
    localparam logic [7:0] CMD_ERGO     = 8'h30;
    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_QUERY    = 8'h98;
    localparam logic [7:0] CMD_RESET    = 8'hF0;
    localparam logic [7:0] CMD_BUFLOAD  = 8'h25;
    localparam logic [7:0] CMD_BUFGO    = 8'h29;
    localparam logic [7:0] CMD_LOCK     = 8'h48;
endpackage

// File: rtl/nor_cmd_seq.sv
// Command sequencer: walks the unlock/command write cycles, keeps the
// read mode and the abort flag, and emits one-cycle start pulses.
// Assumes ADDR_W >= 7 (key addresses 0x55 and 0x2A) and BUF_MAX a power of 2.
// Writes are dropped while ready is low; the top address bit marks the secure region.
module nor_cmd_seq
    import nor_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int DATA_W  = 16,
    parameter int BUF_MAX = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     ready,
    input  logic                     locked,
    output rd_mode_t                 mode,
    output logic                     err,
    output logic                     start_prog,
    output logic                     start_erase,
    output logic                     start_buf,
    output logic                     do_lock,
    output logic                     buf_clr,
    output logic                     buf_we,
    output logic [$clog2(BUF_MAX)-1:0] buf_idx
);
    localparam int BUF_W = $clog2(BUF_MAX);
    localparam int PG_W  = ADDR_W - BUF_W;
    localparam logic [ADDR_W-1:0] KEY_A1 = ADDR_W'(8'h55);
    localparam logic [ADDR_W-1:0] KEY_A2 = ADDR_W'(8'h2A);

    seq_t             seq_q, seq_d;
    rd_mode_t         mode_q, mode_d;
    logic             err_q, err_d;
    logic [PG_W-1:0]  page_q, page_d;
    logic [BUF_W-1:0] left_q, left_d;

    logic       cmd_ok, at_a1, at_a2, in_page, sec_block, data_phase;
    logic [7:0] cb;

    assign cmd_ok     = wr_en && ready;
    assign cb         = wdata[7:0];
    assign at_a1      = (addr == KEY_A1);
    assign at_a2      = (addr == KEY_A2);
    assign in_page    = (addr[ADDR_W-1:BUF_W] == page_q);
    assign sec_block  = locked && addr[ADDR_W-1];
    assign data_phase = (seq_q == SEQ_PROG) || (seq_q == SEQ_BDATA);
    assign buf_idx    = addr[BUF_W-1:0];

    // Next-state decode of the current write against the sequence position.
    always_comb begin
        seq_d = seq_q; mode_d = mode_q; err_d = err_q;
        page_d = page_q; left_d = left_q;
        start_prog = 1'b0; start_erase = 1'b0; start_buf = 1'b0;
        do_lock = 1'b0; buf_clr = 1'b0; buf_we = 1'b0;
        if (cmd_ok) begin
            if (!data_phase && cb == CMD_RESET) begin
                seq_d = SEQ_IDLE; mode_d = MODE_ARRAY; err_d = 1'b0;
            end else begin
                case (seq_q)
                    SEQ_IDLE: begin
                        if (cb == CMD_QUERY && at_a1 && mode_q != MODE_QUERY)
                            mode_d = MODE_QUERY;
                        else if (mode_q == MODE_ARRAY && cb == CMD_KEY1 && at_a1)
                            seq_d = SEQ_UL1;
                    end
                    SEQ_UL1: seq_d = (cb == CMD_KEY2 && at_a2) ? SEQ_UL2 : SEQ_IDLE;
                    SEQ_UL2: begin
                        seq_d = SEQ_IDLE;
                        if (at_a1 && cb == CMD_PROG)         seq_d = SEQ_PROG;
                        else if (at_a1 && cb == CMD_ERSETUP) seq_d = SEQ_ER1;
                        else if (at_a1 && cb == CMD_IDENT)   mode_d = MODE_IDENT;
                        else if (at_a1 && cb == CMD_LOCK)    do_lock = 1'b1;
                        else if (cb == CMD_BUFLOAD) begin
                            seq_d  = SEQ_BCNT;
                            page_d = addr[ADDR_W-1:BUF_W];
                        end
                    end
                    SEQ_PROG: begin
                        seq_d = SEQ_IDLE;
                        start_prog = !sec_block;
                    end
                    SEQ_ER1: seq_d = (cb == CMD_KEY1 && at_a1) ? SEQ_ER2 : SEQ_IDLE;
                    SEQ_ER2: seq_d = (cb == CMD_KEY2 && at_a2) ? SEQ_ER3 : SEQ_IDLE;
                    SEQ_ER3: begin
                        seq_d = SEQ_IDLE;
                        start_erase = (cb == CMD_ERGO) && !sec_block;
                    end
                    SEQ_BCNT: begin
                        if (!in_page || wdata >= DATA_W'(BUF_MAX)) begin
                            err_d = 1'b1; seq_d = SEQ_IDLE;
                        end else begin
                            left_d = wdata[BUF_W-1:0];
                            buf_clr = 1'b1; seq_d = SEQ_BDATA;
                        end
                    end
                    SEQ_BDATA: begin
                        if (!in_page) begin
                            err_d = 1'b1; seq_d = SEQ_IDLE;
                        end else begin
                            buf_we = 1'b1;
                            if (left_q == '0) seq_d = SEQ_BCONF;
                            else              left_d = left_q - 1'b1;
                        end
                    end
                    SEQ_BCONF: begin
                        seq_d = SEQ_IDLE;
                        if (in_page && cb == CMD_BUFGO) start_buf = !sec_block;
                        else                            err_d = 1'b1;
                    end
                    default: seq_d = SEQ_IDLE;
                endcase
            end
        end
    end

    // Sequence, mode and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= SEQ_IDLE; mode_q <= MODE_ARRAY; err_q <= 1'b0;
            page_q <= '0; left_q <= '0;
        end else begin
            seq_q <= seq_d; mode_q <= mode_d; err_q <= err_d;
            page_q <= page_d; left_q <= left_d;
        end
    end

    assign mode = mode_q;
    assign err  = err_q;
endmodule

// File: rtl/nor_wbuf.sv
// Write buffer: holds up to BUF_MAX words for a buffered program.
// Unloaded slots stay at all ones so they leave the array unchanged.
// Assumes contents are only touched while the array is idle.
module nor_wbuf #(
    parameter int DATA_W  = 16,
    parameter int BUF_MAX = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr,
    input  logic                              we,
    input  logic [$clog2(BUF_MAX)-1:0]        idx,
    input  logic [DATA_W-1:0]                 din,
    output logic [BUF_MAX-1:0][DATA_W-1:0]    words
);
    // Clear to all ones on reset or load start; store one word per write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < BUF_MAX; i++) words[i] <= '1;
        end else if (we) begin
            words[idx] <= din;
        end
    end
endmodule

// File: rtl/nor_cell_core.sv
// Cell array with flash bit rules and the embedded-operation timer.
// Program ANDs into a word, erase preprograms a sector to zero one word
// per cycle and then sets it to ones, buffer program ANDs a whole page.
// Assumes starts arrive only while ready is high.
module nor_cell_core
    import nor_pkg::*;
#(
    parameter int ADDR_W       = 7,
    parameter int DATA_W       = 16,
    parameter int SECT_W       = 4,
    parameter int BUF_MAX      = 32,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 20
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_prog,
    input  logic                           start_erase,
    input  logic                           start_buf,
    input  logic                           do_lock,
    input  logic [ADDR_W-1:0]              op_addr,
    input  logic [DATA_W-1:0]              op_data,
    input  logic [BUF_MAX-1:0][DATA_W-1:0] buf_words,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [DATA_W-1:0]              rd_word,
    output logic                           ready,
    output logic                           locked
);
    localparam int WORDS       = 1 << ADDR_W;
    localparam int SECT_WORDS  = 1 << SECT_W;
    localparam int BUF_W       = $clog2(BUF_MAX);
    localparam int ERASE_TOTAL = SECT_WORDS + ERASE_CYCLES;
    localparam int MAX_CNT     = (ERASE_TOTAL > PROG_CYCLES) ? ERASE_TOTAL : PROG_CYCLES;
    localparam int CNT_W       = $clog2(MAX_CNT + 1);

    logic [DATA_W-1:0] mem [WORDS];
    logic [CNT_W-1:0]  cnt_q;
    op_t               kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [SECT_W-1:0] pp_q;
    logic              lock_q;

    // Operation launch, busy countdown, preprogram walk and final commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
            cnt_q <= '0; kind_q <= OP_NONE; addr_q <= '0;
            data_q <= '0; pp_q <= '0; lock_q <= 1'b0;
        end else begin
            if (do_lock) lock_q <= 1'b1;
            if (cnt_q == '0) begin
                if (start_prog) begin
                    cnt_q <= CNT_W'(PROG_CYCLES); kind_q <= OP_PROG;
                    addr_q <= op_addr; data_q <= op_data;
                end else if (start_erase) begin
                    cnt_q <= CNT_W'(ERASE_TOTAL); kind_q <= OP_ERASE;
                    addr_q <= op_addr; pp_q <= '0;
                end else if (start_buf) begin
                    cnt_q <= CNT_W'(PROG_CYCLES); kind_q <= OP_BUF;
                    addr_q <= op_addr;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
                if (kind_q == OP_ERASE && cnt_q > CNT_W'(ERASE_CYCLES)) begin
                    mem[{addr_q[ADDR_W-1:SECT_W], pp_q}] <= '0;
                    pp_q <= pp_q + 1'b1;
                end
                if (cnt_q == CNT_W'(1)) begin
                    case (kind_q)
                        OP_PROG:  mem[addr_q] <= mem[addr_q] & data_q;
                        OP_ERASE: for (int j = 0; j < SECT_WORDS; j++)
                                      mem[{addr_q[ADDR_W-1:SECT_W], SECT_W'(j)}] <= '1;
                        OP_BUF:   for (int j = 0; j < BUF_MAX; j++)
                                      mem[{addr_q[ADDR_W-1:BUF_W], BUF_W'(j)}] <=
                                          mem[{addr_q[ADDR_W-1:BUF_W], BUF_W'(j)}] & buf_words[j];
                        default: ;
                    endcase
                    kind_q <= OP_NONE;
                end
            end
        end
    end

    assign rd_word = mem[rd_addr];
    assign ready   = (cnt_q == '0);
    assign locked  = lock_q;
endmodule

// File: rtl/nor_cmd_array.sv
// Top of the NOR flash command array model: joins the sequencer, write
// buffer and cell core, and registers the read word from the mode mux.
// Assumes one read or write per cycle from a synchronous host.
module nor_cmd_array
    import nor_pkg::*;
#(
    parameter int ADDR_W       = 7,
    parameter int DATA_W       = 16,
    parameter int SECT_W       = 4,
    parameter int BUF_MAX      = 32,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 20,
    parameter logic [15:0] MFR_CODE = 16'h00A5,
    parameter logic [15:0] DEV_CODE = 16'h5A3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic              err
);
    localparam int BUF_W = $clog2(BUF_MAX);

    rd_mode_t                    mode_w;
    logic                        st_prog, st_erase, st_buf, st_lock;
    logic                        buf_clr, buf_we, locked_w;
    logic [BUF_W-1:0]            buf_idx;
    logic [BUF_MAX-1:0][DATA_W-1:0] buf_words;
    logic [DATA_W-1:0]           cell_word, rd_next;

    nor_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_MAX(BUF_MAX)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .ready(ready), .locked(locked_w), .mode(mode_w), .err(err),
        .start_prog(st_prog), .start_erase(st_erase), .start_buf(st_buf),
        .do_lock(st_lock), .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(buf_idx)
    );

    nor_wbuf #(.DATA_W(DATA_W), .BUF_MAX(BUF_MAX)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
        .idx(buf_idx), .din(wdata), .words(buf_words)
    );

    nor_cell_core #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W), .BUF_MAX(BUF_MAX),
        .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .start_prog(st_prog), .start_erase(st_erase),
        .start_buf(st_buf), .do_lock(st_lock), .op_addr(addr), .op_data(wdata),
        .buf_words(buf_words), .rd_addr(addr), .rd_word(cell_word),
        .ready(ready), .locked(locked_w)
    );

    // Select the word a read returns in the current mode.
    always_comb begin
        rd_next = '0;
        case (mode_w)
            MODE_ARRAY: rd_next = cell_word;
            MODE_IDENT: begin
                if (addr == ADDR_W'(0))      rd_next = DATA_W'(MFR_CODE);
                else if (addr == ADDR_W'(1)) rd_next = DATA_W'(DEV_CODE);
                else if (addr == ADDR_W'(3)) rd_next[7] = locked_w;
            end
            MODE_QUERY: begin
                if (addr == ADDR_W'(8'h10))      rd_next = DATA_W'(8'h51);
                else if (addr == ADDR_W'(8'h11)) rd_next = DATA_W'(8'h52);
                else if (addr == ADDR_W'(8'h12)) rd_next = DATA_W'(8'h59);
                else if (addr == ADDR_W'(8'h13)) rd_next = DATA_W'(BUF_MAX);
            end
            default: rd_next = '0;
        endcase
    end

    // Register the read word on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end
endmodule

// File: rtl/nor_cmd_array_checker.sv
// Protocol checker for nor_cmd_array: lock stickiness, secure rejection,
// busy start and busy quietness, abort without busy.
module nor_cmd_array_checker (
    input logic clk,
    input logic rst_n,
    input logic ready,
    input logic err,
    input logic locked,
    input logic start_prog,
    input logic start_erase,
    input logic start_buf,
    input logic do_lock,
    input logic op_msb
);
    logic any_start;
    assign any_start = start_prog || start_erase || start_buf;

    assert_lock_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    assert_secure_reject_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && op_msb) |-> !any_start);

    assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any_start |=> !ready);

    assert_busy_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !(any_start || do_lock));

    assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ready);
endmodule

bind nor_cmd_array nor_cmd_array_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .err(err), .locked(locked_w),
    .start_prog(st_prog), .start_erase(st_erase), .start_buf(st_buf),
    .do_lock(st_lock), .op_msb(addr[ADDR_W-1])
);

// File: tb/nor_cmd_array_bench.sv
// Bench: behavioural model of memory, mode, err, lock and busy length,
// compared with ready/err on every clock and with rdata on each read.
module nor_cmd_array_bench;
    localparam int P_CYC = 8;
    localparam int E_CYC = 16 + 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rdata;
    logic        ready, err;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit mon_on = 0;

    logic [15:0] exp_mem [128];
    int  exp_mode = 0;
    bit  exp_err = 0;
    bit  exp_locked = 0;
    int  exp_busy = 0;

    always #10 clk = ~clk;

    nor_cmd_array u_nor_cmd_array (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .ready(ready), .err(err)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of ready and err with the model (R6, R11).
    always @(negedge clk) begin
        if (mon_on) begin
            check("R6 ready", {15'b0, ready}, {15'b0, exp_busy == 0});
            check("R11 err", {15'b0, err}, {15'b0, exp_err});
            if (exp_busy > 0) exp_busy--;
        end
    end

    function automatic logic [15:0] model_read(input int a);
        if (exp_mode == 0) return exp_mem[a];
        if (exp_mode == 1) begin
            if (a == 0) return 16'h00A5;
            if (a == 1) return 16'h5A3C;
            if (a == 3) return exp_locked ? 16'h0080 : 16'h0000;
            return 16'h0;
        end
        if (a == 16'h10) return 16'h0051;
        if (a == 16'h11) return 16'h0052;
        if (a == 16'h12) return 16'h0059;
        if (a == 16'h13) return 16'd32;
        return 16'h0;
    endfunction

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        addr = 7'(a); wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input string tag);
        @(negedge clk);
        addr = 7'(a); rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
        @(negedge clk);
        check(tag, rdata, model_read(a));
    endtask

    task automatic wait_ready();
        while (exp_busy != 0) @(posedge clk);
        #1;
    endtask

    task automatic unlock();
        wr(8'h55, 16'h00AA);
        wr(8'h2A, 16'h0055);
    endtask

    task automatic prog_word(input int a, input logic [15:0] d);
        unlock(); wr(8'h55, 16'h00A0); wr(a, d);
        if (!(exp_locked && a >= 64)) begin
            exp_mem[a] = exp_mem[a] & d;
            exp_busy = P_CYC;
        end
        wait_ready();
    endtask

    task automatic erase_start(input int a);
        unlock(); wr(8'h55, 16'h0080); unlock(); wr(a, 16'h0030);
        if (!(exp_locked && a >= 64)) begin
            for (int j = 0; j < 16; j++) exp_mem[(a & ~15) + j] = 16'h0000;
            exp_busy = E_CYC;
        end
    endtask

    task automatic erase_finish(input int a);
        wait_ready();
        if (!(exp_locked && a >= 64))
            for (int j = 0; j < 16; j++) exp_mem[(a & ~15) + j] = 16'hFFFF;
    endtask

    task automatic reset_cmd();
        wr(0, 16'h00F0);
        exp_mode = 0; exp_err = 0;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) exp_mem[i] = 16'hFFFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1;

        // R1: reset state
        rd(0, "R1 reset word0");
        rd(77, "R1 reset word77");
        rd(127, "R1 reset word127");

        // R2: AND semantics; F0 in data cycle is data
        prog_word(5, 16'h0FF0);
        rd(5, "R2 first program");
        prog_word(5, 16'hF0F0);
        rd(5, "R2 AND of two programs");
        prog_word(6, 16'h12F0);
        rd(6, "R2 F0 byte as data");

        // R5: broken sequences change nothing
        wr(8'h55, 16'h00AA); wr(8'h2B, 16'h0055); wr(8'h55, 16'h00A0); wr(7, 16'h0000);
        rd(7, "R5 wrong unlock address");
        unlock(); wr(8'h55, 16'h00A1); wr(7, 16'h0000);
        rd(7, "R5 wrong command code");

        // R6: writes while busy are ignored
        unlock(); wr(8'h55, 16'h00A0); wr(8, 16'hFF00);
        exp_mem[8] = exp_mem[8] & 16'hFF00; exp_busy = P_CYC;
        unlock(); wr(8'h55, 16'h00A0); wr(9, 16'h0000);
        wait_ready();
        rd(8, "R6 accepted program");
        rd(9, "R6 write during busy ignored");

        // R3, R4: erase sector 1 with preprogram
        prog_word(20, 16'h1111);
        prog_word(33, 16'h3333);
        erase_start(20);
        repeat (20) @(negedge clk);
        rd(25, "R4 preprogrammed word mid-erase");
        rd(16, "R4 preprogrammed first word");
        erase_finish(20);
        rd(20, "R3 erased word");
        rd(31, "R3 erased last word");
        rd(5, "R3 other sector kept");
        rd(33, "R3 next sector kept");

        // R7, R9: query mode and return
        wr(8'h55, 16'h0098); exp_mode = 2;
        rd(8'h10, "R7 query Q");
        rd(8'h11, "R7 query R");
        rd(8'h12, "R7 query Y");
        rd(8'h13, "R7 query buffer size");
        rd(5, "R7 query other address");
        reset_cmd();
        rd(5, "R9 back to array");

        // R8, R7: identification, then query from it
        unlock(); wr(8'h55, 16'h0090); exp_mode = 1;
        rd(0, "R8 maker code");
        rd(1, "R8 device code");
        rd(3, "R8 unlocked indicator");
        wr(8'h55, 16'h0098); exp_mode = 2;
        rd(8'h10, "R7 query from ident");
        reset_cmd();

        // R10: short buffer in page 1
        unlock(); wr(32, 16'h0025); wr(32, 16'h0002);
        wr(34, 16'h0F0F); wr(40, 16'h00FF); wr(63, 16'hF00F); wr(32, 16'h0029);
        exp_mem[34] &= 16'h0F0F; exp_mem[40] &= 16'h00FF; exp_mem[63] &= 16'hF00F;
        exp_busy = P_CYC;
        wait_ready();
        rd(34, "R10 buffer word a");
        rd(40, "R10 buffer word b");
        rd(63, "R10 buffer word c");
        rd(33, "R10 unloaded word kept");

        // R10: full 32-word page 0, each word clears a different bit
        unlock(); wr(0, 16'h0025); wr(0, 16'd31);
        for (int i = 0; i < 32; i++) wr(i, 16'hFFFF ^ (16'h1 << (i % 16)));
        wr(0, 16'h0029);
        for (int i = 0; i < 32; i++) exp_mem[i] &= 16'hFFFF ^ (16'h1 << (i % 16));
        exp_busy = P_CYC;
        wait_ready();
        for (int i = 0; i < 32; i++) rd(i, "R10 full page word");

        // R11: oversized count, out-of-page address, bad confirm
        unlock(); wr(32, 16'h0025); wr(32, 16'd32); exp_err = 1;
        @(negedge clk); check("R11 count too large", {15'b0, err}, 16'h1);
        rd(34, "R11 no change after count abort");
        reset_cmd();
        @(negedge clk); check("R9 err cleared", {15'b0, err}, 16'h0);
        unlock(); wr(0, 16'h0025); wr(0, 16'h0001); wr(40, 16'h0000); exp_err = 1;
        rd(40, "R11 no change after page abort");
        reset_cmd();
        unlock(); wr(0, 16'h0025); wr(0, 16'h0000); wr(2, 16'h0000); wr(0, 16'h0030); exp_err = 1;
        rd(2, "R11 no change after bad confirm");
        reset_cmd();

        // R12: lock the secure region
        prog_word(70, 16'h1234);
        rd(70, "R12 secure programmable before lock");
        unlock(); wr(8'h55, 16'h0048); exp_locked = 1;
        unlock(); wr(8'h55, 16'h0090); exp_mode = 1;
        rd(3, "R12 locked indicator");
        reset_cmd();
        prog_word(70, 16'h0000);
        rd(70, "R12 program rejected");
        erase_start(70);
        erase_finish(70);
        rd(70, "R12 erase rejected");
        unlock(); wr(64, 16'h0025); wr(64, 16'h0000); wr(70, 16'h0000); wr(64, 16'h0029);
        rd(70, "R12 buffer rejected");
        prog_word(10, 16'h00FF);
        rd(10, "R12 main array still programmable");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule